// File: doc/BRIEF.md
# Overload Cut-off and Thermal Sequencer

This block is the digital control core of a single-channel high-side power switch. It takes the channel command and a set of flags from the analog comparators: current limiting active, over-temperature trip, temperature back below the restart threshold, and supply good. From these it drives the power-stage gate enable, a limiting-mode indicator and an active-low fault line.

When the channel runs into current limitation, the block times the episode against a programmable cycle window. If the limitation outlasts the window, the block cuts the output off. It then holds the output off for a restart pause equal to 32 windows before it follows the command again. Thermal shutdown overrides everything else and can stretch a pending restart pause. Undervoltage lock-out forces the gate off. With the cut-off disabled, the channel may stay in limitation indefinitely.

Top module: `hs_guard_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves `gate_on` low, `fault_n` high and `limiting` low, with all timers cleared.
- R2: With no fault and supply good, `gate_on` takes the value of `sw_in` one clock after it is sampled, and `fault_n` stays high.
- R3: If `ilim_act` is seen while `gate_on` is high, `limiting` rises on the next edge and `coff_cycles` is latched at that edge. If the flag stays set for the latched number of cycles in limitation (a value of 0 counts as 1), the gate goes low and `fault_n` goes low on that edge, and `limiting` drops. Changes to `coff_cycles` during the episode have no effect.
- R4: If `ilim_act` drops before the window ends, the next edge returns to normal with the gate on and no fault. A later episode gets a fresh, full window.
- R5: After a cut-off the gate stays off for 32 times the latched window. On the edge that ends the pause, `fault_n` returns high and the gate follows `sw_in` again.
- R6: While `fault_n` is low the gate is off, and changes on `sw_in` affect neither `fault_n` nor `gate_on`.
- R7: `ot_trip` high forces `gate_on` low and `fault_n` low on the next edge, from any state, including in the middle of a limitation window.
- R8: After a thermal trip, the output stays off with `fault_n` low until `ot_trip` is low and `ot_clear` is high. If a restart pause was running, the pause must also have ended.
- R9: With `coff_en` low, limitation never times out. The channel stays on in limitation until `sw_in` falls, supply is lost or a thermal trip occurs.
- R10: `supply_ok` low forces `gate_on` low on the next edge, whatever `sw_in` is, and ends any limitation episode. The gate follows `sw_in` again one edge after supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 1 | Channel on command |
| ilim_act | input | 1 | Current limitation is active |
| ot_trip | input | 1 | Junction over-temperature trip |
| ot_clear | input | 1 | Temperature is below the restart threshold |
| supply_ok | input | 1 | Supply is above the lock-out threshold |
| coff_en | input | 1 | Enables the timed cut-off |
| coff_cycles | input | 16 | Limitation window in clock cycles |
| gate_on | output | 1 | Power-stage gate enable |
| limiting | output | 1 | Channel is in limitation mode |
| fault_n | output | 1 | Active-low fault output |

## Verification
The bench pins the cut-off to the exact edge of a ten-cycle window. A design that is off by one, or that reloads the window from the live input in mid-episode, cuts one cycle early or late. It then counts the full 320-cycle pause and checks the cycle before and the cycle after. A design that waits a shifted or truncated amount releases the fault at the wrong edge. A thermal trip placed inside a two-cycle cut-off's pause, with the temperature recovering at once, shows whether the design wrongly releases on temperature alone. Further cases cover an early drop of the current flag followed by a fresh window, indefinite limitation with the cut-off disabled, and supply loss in the middle of limitation. Each of these catches a design that leaks the command through a fault or keeps limiting with no supply.

// File: rtl/hs_guard_ctrl.sv
`timescale 1ns/1ps
module hs_guard_ctrl #(
  parameter int CW    = 16,
  parameter int SHIFT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_in,
  input  logic          ilim_act,
  input  logic          ot_trip,
  input  logic          ot_clear,
  input  logic          supply_ok,
  input  logic          coff_en,
  input  logic [CW-1:0] coff_cycles,
  output logic          gate_on,
  output logic          limiting,
  output logic          fault_n
);
  localparam int WW = CW + SHIFT;

  typedef enum logic [1:0] {S_RUN, S_LIMIT, S_RESTART, S_THERM} st_t;

  st_t           st;
  logic          gate_q, flt_q;
  logic [CW-1:0] lim_cnt, win;
  logic [WW-1:0] wait_cnt;

  logic run_ok, cut_due, wait_done, wait_keep;
  assign run_ok    = sw_in & supply_ok;
  assign cut_due   = ({1'b0, lim_cnt} + 1'b1) >= {1'b0, win};
  assign wait_done = (wait_cnt <= 1);
  assign wait_keep = (st == S_RESTART) || (st == S_THERM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_RUN;
      gate_q   <= 1'b0;
      flt_q    <= 1'b1;
      lim_cnt  <= '0;
      win      <= '0;
      wait_cnt <= '0;
    end else if (ot_trip) begin
      st      <= S_THERM;
      gate_q  <= 1'b0;
      flt_q   <= 1'b0;
      lim_cnt <= '0;
      if (!wait_keep)          wait_cnt <= '0;
      else if (wait_cnt != 0)  wait_cnt <= wait_cnt - 1'b1;
    end else begin
      case (st)
        S_RUN: begin
          gate_q <= run_ok;
          flt_q  <= 1'b1;
          if (gate_q && run_ok && ilim_act) begin
            st      <= S_LIMIT;
            win     <= coff_cycles;
            lim_cnt <= '0;
          end
        end
        S_LIMIT: begin
          if (!run_ok) begin
            st      <= S_RUN;
            gate_q  <= 1'b0;
            lim_cnt <= '0;
          end else if (!ilim_act) begin
            st      <= S_RUN;
            gate_q  <= 1'b1;
            lim_cnt <= '0;
          end else if (coff_en && cut_due) begin
            st       <= S_RESTART;
            gate_q   <= 1'b0;
            flt_q    <= 1'b0;
            lim_cnt  <= '0;
            wait_cnt <= {win, {SHIFT{1'b0}}};
          end else if (coff_en) begin
            lim_cnt <= lim_cnt + 1'b1;
          end
        end
        S_RESTART: begin
          if (wait_done) begin
            st       <= S_RUN;
            flt_q    <= 1'b1;
            gate_q   <= run_ok;
            wait_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        default: begin
          if (ot_clear && wait_done) begin
            st       <= S_RUN;
            flt_q    <= 1'b1;
            gate_q   <= run_ok;
            wait_cnt <= '0;
          end else if (wait_cnt != 0) begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_on  = gate_q;
  assign fault_n  = flt_q;
  assign limiting = (st == S_LIMIT);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!gate_on && fault_n && !limiting));

  p_limit_means_on_r3: assert property (@(posedge clk) disable iff (rst)
    limiting |-> gate_on);

  p_fault_gate_off_r6: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> !gate_on);

  p_thermal_off_r7: assert property (@(posedge clk) disable iff (rst)
    ot_trip |=> (!gate_on && !fault_n));

  p_no_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    (limiting && !coff_en && ilim_act && sw_in && supply_ok && !ot_trip) |=> limiting);

  p_uvlo_off_r10: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !gate_on);
endmodule

// File: tb/hs_guard_ctrl_tb.sv
`timescale 1ns/1ps
module hs_guard_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_in = 1'b0, ilim_act = 1'b0, ot_trip = 1'b0, ot_clear = 1'b1;
  logic supply_ok = 1'b1, coff_en = 1'b1;
  logic [15:0] coff_cycles = 16'd10;
  logic gate_on, limiting, fault_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  hs_guard_ctrl u_dut (
    .clk(clk), .rst(rst), .sw_in(sw_in), .ilim_act(ilim_act), .ot_trip(ot_trip),
    .ot_clear(ot_clear), .supply_ok(supply_ok), .coff_en(coff_en),
    .coff_cycles(coff_cycles), .gate_on(gate_on), .limiting(limiting), .fault_n(fault_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    sw_in = 0; ilim_act = 0; ot_trip = 0; ot_clear = 1; supply_ok = 1;
    coff_en = 1; coff_cycles = 16'd10;
    tick(2);
  endtask

  task automatic t_reset();
    sw_in = 1;
    tick(3);
    chk("R1 gate after reset", gate_on, 1'b0);
    chk("R1 fault after reset", fault_n, 1'b1);
    chk("R1 limiting after reset", limiting, 1'b0);
    rst = 0;
    sw_in = 0;
    tick(1);
  endtask

  task automatic t_follow();
    sw_in = 1; tick(1);
    chk("R2 gate follows high", gate_on, 1'b1);
    chk("R2 fault high", fault_n, 1'b1);
    sw_in = 0; tick(1);
    chk("R2 gate follows low", gate_on, 1'b0);
    idle();
  endtask

  task automatic t_cutoff();
    coff_cycles = 16'd10;
    sw_in = 1; tick(1);
    ilim_act = 1; tick(1);
    chk("R3 limiting entered", limiting, 1'b1);
    coff_cycles = 16'd2;
    tick(9);
    chk("R3 gate still on before window end", gate_on, 1'b1);
    chk("R3 no fault before window end", fault_n, 1'b1);
    tick(1);
    chk("R3 gate cut at window end", gate_on, 1'b0);
    chk("R3 fault at cut", fault_n, 1'b0);
    chk("R3 limiting cleared at cut", limiting, 1'b0);
    ilim_act = 0; sw_in = 0;
    tick(100);
    chk("R6 fault low with sw_in low", fault_n, 1'b0);
    sw_in = 1; tick(1);
    chk("R6 gate stays off with sw_in high", gate_on, 1'b0);
    tick(218);
    chk("R5 fault low one cycle before pause end", fault_n, 1'b0);
    chk("R5 gate off one cycle before pause end", gate_on, 1'b0);
    tick(1);
    chk("R5 fault released at pause end", fault_n, 1'b1);
    chk("R5 gate follows sw_in at pause end", gate_on, 1'b1);
    idle();
  endtask

  task automatic t_early_drop();
    coff_cycles = 16'd10;
    sw_in = 1; tick(1);
    ilim_act = 1; tick(1);
    tick(4);
    ilim_act = 0; tick(1);
    chk("R4 limiting ends on flag drop", limiting, 1'b0);
    chk("R4 gate stays on", gate_on, 1'b1);
    chk("R4 no fault", fault_n, 1'b1);
    ilim_act = 1; tick(1);
    chk("R4 new episode", limiting, 1'b1);
    tick(9);
    chk("R4 fresh window not cut early", gate_on, 1'b1);
    tick(1);
    chk("R4 fresh window cuts on time", gate_on, 1'b0);
    ilim_act = 0; sw_in = 0;
    tick(320);
    chk("R5 fault released after pause", fault_n, 1'b1);
    chk("R5 gate low with sw_in low", gate_on, 1'b0);
    idle();
  endtask

  task automatic t_thermal();
    ot_trip = 1; tick(1);
    chk("R7 fault on trip while idle", fault_n, 1'b0);
    ot_trip = 0; tick(1);
    chk("R7 recovers from idle trip", fault_n, 1'b1);
    coff_cycles = 16'd10;
    sw_in = 1; tick(1);
    ilim_act = 1; tick(1);
    tick(3);
    ot_trip = 1; ot_clear = 0; tick(1);
    chk("R7 gate off on trip in window", gate_on, 1'b0);
    chk("R7 fault low on trip", fault_n, 1'b0);
    chk("R7 limiting cleared", limiting, 1'b0);
    ot_trip = 0; tick(20);
    chk("R8 held off while hot", gate_on, 1'b0);
    chk("R8 fault held while hot", fault_n, 1'b0);
    sw_in = 0; tick(1);
    chk("R6 fault independent of sw_in", fault_n, 1'b0);
    sw_in = 1; ilim_act = 0; ot_clear = 1; tick(1);
    chk("R8 released on cool-down", fault_n, 1'b1);
    chk("R8 gate back on", gate_on, 1'b1);
    idle();
  endtask

  task automatic t_therm_restart();
    coff_cycles = 16'd2;
    sw_in = 1; tick(1);
    ilim_act = 1; tick(1);
    tick(2);
    chk("R3 two-cycle window cuts", fault_n, 1'b0);
    ilim_act = 0; ot_trip = 1; ot_clear = 0; tick(1);
    ot_trip = 0; ot_clear = 1;
    tick(62);
    chk("R8 pause still holds after cool-down", fault_n, 1'b0);
    chk("R8 gate held in pause", gate_on, 1'b0);
    tick(1);
    chk("R8 released when pause ends", fault_n, 1'b1);
    chk("R8 gate on when pause ends", gate_on, 1'b1);
    idle();
  endtask

  task automatic t_nocut();
    coff_en = 0; coff_cycles = 16'd3;
    sw_in = 1; tick(1);
    ilim_act = 1; tick(1);
    tick(50);
    chk("R9 still limiting", limiting, 1'b1);
    chk("R9 gate still on", gate_on, 1'b1);
    chk("R9 no fault", fault_n, 1'b1);
    sw_in = 0; tick(1);
    chk("R9 ends on sw_in low", gate_on, 1'b0);
    chk("R9 limiting cleared", limiting, 1'b0);
    chk("R9 no fault after", fault_n, 1'b1);
    idle();
  endtask

  task automatic t_uvlo();
    sw_in = 1; tick(1);
    chk("R10 gate on with supply", gate_on, 1'b1);
    supply_ok = 0; tick(1);
    chk("R10 gate off in lock-out", gate_on, 1'b0);
    tick(5);
    chk("R10 gate held off", gate_on, 1'b0);
    supply_ok = 1; tick(1);
    chk("R10 resumes", gate_on, 1'b1);
    ilim_act = 1; tick(1);
    chk("R10 limiting before loss", limiting, 1'b1);
    supply_ok = 0; tick(1);
    chk("R10 limiting ends on loss", limiting, 1'b0);
    chk("R10 gate off on loss", gate_on, 1'b0);
    supply_ok = 1; ilim_act = 0; tick(1);
    chk("R10 gate back after loss", gate_on, 1'b1);
    idle();
  endtask

  initial begin
    t_reset();
    t_follow();
    t_cutoff();
    t_early_drop();
    t_thermal();
    t_therm_restart();
    t_nocut();
    t_uvlo();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule